// File: doc/BRIEF.md
# USB Low-Speed Packet Transmitter

This block puts one low-speed USB packet onto the D+/D- pair. A packet is a sync byte followed by one to eleven further bytes. A single start strobe selects one of two packet kinds. A data packet fetches its payload bytes one at a time through a byte-read port. A handshake packet is the sync byte followed by a PID byte taken from an input. The block NRZI-encodes the bit stream and inserts stuffed bits. It ends the packet with SE0 followed by J, then lets go of the bus.

The block owns the whole bus-ownership sequence. It presets the pins to the idle J level before it enables the drivers. After the final J bit it disables the drivers, and both pins read low so that no pull-up stays active. When a data packet (not a handshake) has been sent, the block copies a pending device address into the active address output as it releases the bus. CRC generation and the decision to reply are left to the logic around the block.

Top module: `usb_ls_tx`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to idle: `busy_o`=0, `oe_o`=0, `dp_o`=0, `dm_o`=0 and `dev_addr_o`=0. This holds even in the middle of a packet.
- R2: A `start_i` seen in idle raises `busy_o` from the next clock. For exactly that one clock the pins show J (`dm_o`=1, `dp_o`=0) with `oe_o`=0. From the clock after that, `oe_o`=1.
- R3: Every bit on the wire, including stuffed and end-of-packet bits, lasts exactly CLKS_PER_BIT clocks (11 by default). The first bit starts right after the one-clock preset.
- R4: The byte sequence is 0x80 (sync), then the payload bytes read at `rd_addr_o` = 0, 1, 2 and so on. Each byte goes out LSB first. In NRZI, a 0 toggles the line and a 1 holds it, starting from J. J is `dm_o`=1/`dp_o`=0 and K is `dp_o`=1/`dm_o`=0.
- R5: After six consecutive 1 bits, an extra toggle bit is sent. The run of ones is counted across byte boundaries, and a stuffed bit is still sent when the run ends on the last data bit.
- R6: `len_i` gives the total byte count including sync. Values below 2 act as 2 and values above MAX_BYTES (12) act as MAX_BYTES.
- R7: With `hs_sel_i`=1 at start, the packet is sync followed by `hs_pid_i`, and `len_i` has no effect.
- R8: After the last data bit, the block drives SE0 (both pins low, `oe_o`=1) for two bit times and then J for one bit time.
- R9: After the J bit, `oe_o`=0, `dp_o`=`dm_o`=0 and `busy_o`=0, all on the same clock.
- R10: `new_addr_i` is copied into `dev_addr_o` at the release that ends a data packet. A handshake packet leaves `dev_addr_o` unchanged.
- R11: A `start_i` received while `busy_o`=1 is ignored. The current packet is unaffected and no second packet follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start strobe, taken only when idle |
| hs_sel_i | input | 1 | 1 = handshake packet, 0 = data packet |
| hs_pid_i | input | 8 | Handshake PID byte |
| len_i | input | LEN_W (4) | Total byte count including sync |
| rd_addr_o | output | LEN_W (4) | Payload byte index being requested |
| rd_data_i | input | 8 | Payload byte at `rd_addr_o`, same cycle |
| new_addr_i | input | ADDR_W (7) | Pending device address |
| dev_addr_o | output | ADDR_W (7) | Active device address |
| dp_o | output | 1 | D+ level |
| dm_o | output | 1 | D- level |
| oe_o | output | 1 | Driver enable for both pins |
| busy_o | output | 1 | High from start until release |

## Verification
If the ones counter is wrong, the line shows a misplaced or missing toggle within one bit time of the sixth 1. Every later NRZI level then differs from the reference, so the fault cannot stay hidden until the end of the packet. If the byte index or length latch is wrong, the packet has a different bit count, and SE0 appears at the wrong bit slot. If the state sequencing is wrong, the fault shows on the very next clock as an enable rising without J on the pins, or as a release without a J bit before it. A commit after a handshake changes the address output on the release clock.

// File: rtl/usb_tx_pkg.sv
// Shared types and constants for the low-speed transmitter.
// Assumes: bytes go out LSB first and J is the idle level.
package usb_tx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRESET,
        ST_DATA,
        ST_SE0,
        ST_EOPJ
    } tx_state_t;

    localparam logic [7:0] SYNC_BYTE = 8'h80;
    localparam int         STUFF_RUN = 6;
endpackage

// File: rtl/usb_tx_bit_timer.sv
// Bit-period timer: while run_i is high, pulses tick_o on the last clock
// of every CLKS_PER_BIT-clock bit. Assumes run_i is low for at least one
// clock before a packet, which clears the count.
module usb_tx_bit_timer #(
    parameter int CLKS_PER_BIT = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int CW = $clog2(CLKS_PER_BIT);
    localparam logic [CW-1:0] LAST = CW'(CLKS_PER_BIT - 1);

    logic [CW-1:0] cnt_q;

    assign tick_o = run_i && (cnt_q == LAST);

    // Count clocks inside the current bit; clear when idle or on a tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i || tick_o) cnt_q <= '0;
        else                            cnt_q <= cnt_q + CW'(1);
    end

    // R3: the count never leaves the bit period
    a_r3_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
endmodule

// File: rtl/usb_tx_serializer.sv
// Byte serializer with bit stuffing and NRZI. Each adv_i puts the next
// wire bit on line_o (1 = J). The first byte is the sync byte. The next
// byte comes from rd_data_i, or from the latched PID for a handshake.
// last_o flags that the bit now on the wire is the final one.
// Assumes: load_i and adv_i are never high together.
module usb_tx_serializer
    import usb_tx_pkg::*;
#(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             hs_i,
    input  logic [7:0]       pid_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             adv_i,
    input  logic [7:0]       rd_data_i,
    output logic [LEN_W-1:0] rd_addr_o,
    output logic             line_o,
    output logic             last_o
);
    localparam logic [2:0] RUN = 3'(STUFF_RUN);

    logic [7:0]       shreg_q;
    logic [2:0]       bit_q;
    logic [LEN_W-1:0] byte_q;
    logic [LEN_W-1:0] len_q;
    logic             hs_q;
    logic [7:0]       pid_q;
    logic [2:0]       ones_q;
    logic             empty_q;
    logic             line_q;
    logic [7:0]       next_byte;

    assign next_byte = hs_q ? pid_q : rd_data_i;
    assign rd_addr_o = byte_q;
    assign line_o    = line_q;
    assign last_o    = empty_q && (ones_q != RUN);

    // Load a packet, then emit one stuffed or data bit per advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
            bit_q   <= '0;
            byte_q  <= '0;
            len_q   <= '0;
            hs_q    <= 1'b0;
            pid_q   <= '0;
            ones_q  <= '0;
            empty_q <= 1'b0;
            line_q  <= 1'b1;
        end else if (load_i) begin
            shreg_q <= SYNC_BYTE;
            bit_q   <= '0;
            byte_q  <= '0;
            len_q   <= len_i;
            hs_q    <= hs_i;
            pid_q   <= pid_i;
            ones_q  <= '0;
            empty_q <= 1'b0;
            line_q  <= 1'b1;
        end else if (adv_i) begin
            if (ones_q == RUN) begin
                line_q <= ~line_q;
                ones_q <= '0;
            end else if (!empty_q) begin
                if (shreg_q[0]) begin
                    ones_q <= ones_q + 3'd1;
                end else begin
                    line_q <= ~line_q;
                    ones_q <= '0;
                end
                bit_q <= bit_q + 3'd1;
                if (bit_q == 3'd7) begin
                    if (byte_q == len_q - LEN_W'(1)) begin
                        empty_q <= 1'b1;
                    end else begin
                        shreg_q <= next_byte;
                        byte_q  <= byte_q + LEN_W'(1);
                    end
                end else begin
                    shreg_q <= shreg_q >> 1;
                end
            end
        end
    end

    // R5: a full run of ones forces a line toggle on the next bit
    a_r5_stuff_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !load_i && ones_q == RUN) |=> (line_q != $past(line_q)));

    // R5: a run of ones never grows past the stuffing limit
    a_r5_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (ones_q == RUN && adv_i) |=> (ones_q == 3'd0));
endmodule

// File: rtl/usb_ls_tx.sv
// Low-speed USB packet transmitter top. Sequences the pins through
// preset J, data bits, two bits of SE0, one bit of J, then release. The
// active address is committed only at the end of a data packet.
// Assumes: rd_data_i is valid in the same cycle as rd_addr_o.
module usb_ls_tx
    import usb_tx_pkg::*;
#(
    parameter int CLKS_PER_BIT = 11,
    parameter int MAX_BYTES    = 12,
    parameter int ADDR_W       = 7,
    parameter int LEN_W        = $clog2(MAX_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              hs_sel_i,
    input  logic [7:0]        hs_pid_i,
    input  logic [LEN_W-1:0]  len_i,
    output logic [LEN_W-1:0]  rd_addr_o,
    input  logic [7:0]        rd_data_i,
    input  logic [ADDR_W-1:0] new_addr_i,
    output logic [ADDR_W-1:0] dev_addr_o,
    output logic              dp_o,
    output logic              dm_o,
    output logic              oe_o,
    output logic              busy_o
);
    localparam logic [LEN_W-1:0] MIN_LEN = LEN_W'(2);
    localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(MAX_BYTES);

    tx_state_t         state_q;
    logic              se0_two_q;
    logic              hs_q;
    logic [ADDR_W-1:0] dev_addr_q;
    logic              tick;
    logic              run;
    logic              load;
    logic              adv;
    logic              line;
    logic              ser_last;
    logic [LEN_W-1:0]  len_eff;

    // Clamp the requested length into the legal range; handshakes are two bytes.
    always_comb begin
        if (hs_sel_i || len_i < MIN_LEN) len_eff = MIN_LEN;
        else if (len_i > MAX_LEN)        len_eff = MAX_LEN;
        else                             len_eff = len_i;
    end

    assign load = (state_q == ST_IDLE) && start_i;
    assign run  = (state_q == ST_DATA) || (state_q == ST_SE0) || (state_q == ST_EOPJ);
    assign adv  = (state_q == ST_PRESET) ||
                  ((state_q == ST_DATA) && tick && !ser_last);

    usb_tx_bit_timer #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .tick_o (tick)
    );

    usb_tx_serializer #(.LEN_W(LEN_W)) u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load),
        .hs_i      (hs_sel_i),
        .pid_i     (hs_pid_i),
        .len_i     (len_eff),
        .adv_i     (adv),
        .rd_data_i (rd_data_i),
        .rd_addr_o (rd_addr_o),
        .line_o    (line),
        .last_o    (ser_last)
    );

    // Packet sequencer and address commit at release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            se0_two_q  <= 1'b0;
            hs_q       <= 1'b0;
            dev_addr_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (start_i) begin
                    state_q <= ST_PRESET;
                    hs_q    <= hs_sel_i;
                end
                ST_PRESET: state_q <= ST_DATA;
                ST_DATA: if (tick && ser_last) state_q <= ST_SE0;
                ST_SE0: if (tick) begin
                    se0_two_q <= ~se0_two_q;
                    if (se0_two_q) state_q <= ST_EOPJ;
                end
                ST_EOPJ: if (tick) begin
                    state_q <= ST_IDLE;
                    if (!hs_q) dev_addr_q <= new_addr_i;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Pin levels per state: J is dm high / dp low, undriven pins read low.
    always_comb begin
        case (state_q)
            ST_PRESET: begin dp_o = 1'b0;  dm_o = 1'b1; oe_o = 1'b0; end
            ST_DATA:   begin dp_o = ~line; dm_o = line; oe_o = 1'b1; end
            ST_SE0:    begin dp_o = 1'b0;  dm_o = 1'b0; oe_o = 1'b1; end
            ST_EOPJ:   begin dp_o = 1'b0;  dm_o = 1'b1; oe_o = 1'b1; end
            default:   begin dp_o = 1'b0;  dm_o = 1'b0; oe_o = 1'b0; end
        endcase
    end

    assign busy_o     = (state_q != ST_IDLE);
    assign dev_addr_o = dev_addr_q;

    // R2: drivers switch on only after the pins already showed J
    a_r2_preset_before_drive: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_o) |-> ($past(dm_o) && !$past(dp_o) && $past(busy_o)));

    // R8, R9: the last driven level before release is J
    a_r9_release_after_j: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(oe_o) |-> ($past(dm_o) && !$past(dp_o)));

    // R10: the address only changes on the release clock
    a_r10_addr_at_release: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dev_addr_o) |-> $fell(busy_o));

    // R10: a handshake packet never commits the address
    a_r10_no_commit_after_hs: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dev_addr_o) |-> !$past(hs_q));

    // R9: not driving means both pins low, except the one-clock preset
    a_r9_idle_pins_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_o && !busy_o) |-> (!dp_o && !dm_o));
endmodule

// File: tb/sim_usb_ls_tx.sv
`timescale 1ns/1ps
module sim_usb_ls_tx;
    localparam int CPB = 11;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       hs_sel_i = 1'b0;
    logic [7:0] hs_pid_i = '0;
    logic [3:0] len_i = '0;
    logic [3:0] rd_addr_o;
    logic [7:0] rd_data_i;
    logic [6:0] new_addr_i = '0;
    logic [6:0] dev_addr_o;
    logic       dp_o, dm_o, oe_o, busy_o;

    logic [7:0] mem [16];
    logic       exp_l [200];
    int         n_bits;
    int         tests = 0;
    int         fails = 0;
    logic [6:0] exp_addr = '0;

    always #2 clk = ~clk;

    assign rd_data_i = mem[rd_addr_o];

    usb_ls_tx u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .hs_sel_i(hs_sel_i),
        .hs_pid_i(hs_pid_i), .len_i(len_i), .rd_addr_o(rd_addr_o),
        .rd_data_i(rd_data_i), .new_addr_i(new_addr_i), .dev_addr_o(dev_addr_o),
        .dp_o(dp_o), .dm_o(dm_o), .oe_o(oe_o), .busy_o(busy_o)
    );

    // Vectors: [31] hs, [30:23] pid, [22:19] len, [18:12] addr, [11:10] kind, [7:0] seed
    localparam logic [31:0] VEC [7] = '{
        {1'b0, 8'h00, 4'd4,  7'h15, 2'd0, 2'b0, 8'h3C},
        {1'b0, 8'h00, 4'd3,  7'h2A, 2'd1, 2'b0, 8'h00},
        {1'b1, 8'hD2, 4'd9,  7'h55, 2'd0, 2'b0, 8'h00},
        {1'b1, 8'h5A, 4'd1,  7'h11, 2'd1, 2'b0, 8'h00},
        {1'b0, 8'h00, 4'd12, 7'h7F, 2'd2, 2'b0, 8'h9B},
        {1'b0, 8'h00, 4'd15, 7'h01, 2'd0, 2'b0, 8'hF0},
        {1'b0, 8'h00, 4'd0,  7'h33, 2'd1, 2'b0, 8'h00}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Reference bit stream: sync + bytes, LSB first, stuffing, NRZI from J.
    task automatic build(input logic [31:0] v);
        logic [7:0] bytes [12];
        int nb;
        int ones;
        logic lvl;
        bytes[0] = 8'h80;
        if (v[31]) begin
            bytes[1] = v[30:23];
            nb = 2;
        end else begin
            nb = (v[22:19] < 2) ? 2 : (v[22:19] > 12) ? 12 : int'(v[22:19]);
            for (int k = 1; k < nb; k++) bytes[k] = mem[k-1];
        end
        lvl = 1'b1;
        ones = 0;
        n_bits = 0;
        for (int k = 0; k < nb; k++) begin
            for (int b = 0; b < 8; b++) begin
                if (bytes[k][b]) ones++;
                else begin lvl = ~lvl; ones = 0; end
                exp_l[n_bits] = lvl;
                n_bits++;
                if (ones == 6) begin
                    lvl = ~lvl;
                    ones = 0;
                    exp_l[n_bits] = lvl;
                    n_bits++;
                end
            end
        end
    endtask

    task automatic run_pkt(input logic [31:0] v, input bit poke);
        int mism;
        int bad_busy;
        @(negedge clk);
        for (int i = 0; i < 16; i++) begin
            case (v[11:10])
                2'd0:    mem[i] = v[7:0] + 8'(i * 17);
                2'd1:    mem[i] = 8'hFF;
                default: mem[i] = v[7:0] ^ 8'(i * 37);
            endcase
        end
        hs_sel_i   = v[31];
        hs_pid_i   = v[30:23];
        len_i      = v[22:19];
        new_addr_i = v[18:12];
        start_i    = 1'b1;
        build(v);
        @(negedge clk);
        start_i = 1'b0;
        // R2: one clock of J preset with drivers off
        chk(busy_o && !oe_o && dm_o && !dp_o, "R2", "preset {busy,oe,dm,dp}",
            {busy_o, oe_o, dm_o, dp_o}, 4'b1010);
        @(negedge clk);
        chk(oe_o === 1'b1, "R2", "drive after preset", oe_o, 1);
        mism = 0;
        bad_busy = 0;
        for (int i = 0; i < n_bits; i++) begin
            repeat (5) @(negedge clk);
            if (!(oe_o && dm_o == exp_l[i] && dp_o == !exp_l[i])) mism++;
            if (!busy_o) bad_busy++;
            if (poke && i == 3) begin
                start_i  = 1'b1;
                hs_sel_i = ~hs_sel_i;
                len_i    = 4'd2;
                @(negedge clk);
                start_i = 1'b0;
                repeat (5) @(negedge clk);
            end else begin
                repeat (6) @(negedge clk);
            end
        end
        // R3 R4 R5 R6 R7: every bit level at its mid-bit sample
        chk(mism == 0, "R4/R5", "mismatched bits", mism, 0);
        chk(bad_busy == 0, "R3", "busy dropped during data", bad_busy, 0);
        for (int s = 0; s < 2; s++) begin
            repeat (5) @(negedge clk);
            chk(oe_o && !dp_o && !dm_o, "R8", "SE0 {oe,dp,dm}",
                {oe_o, dp_o, dm_o}, 3'b100);
            repeat (6) @(negedge clk);
        end
        repeat (5) @(negedge clk);
        chk(oe_o && !dp_o && dm_o, "R8", "EOP J {oe,dp,dm}", {oe_o, dp_o, dm_o}, 3'b101);
        repeat (5) @(negedge clk);
        chk(busy_o && oe_o, "R3", "still J on last bit clock", {busy_o, oe_o}, 2'b11);
        @(negedge clk);
        chk(!busy_o && !oe_o && !dp_o && !dm_o, "R9", "release {busy,oe,dp,dm}",
            {busy_o, oe_o, dp_o, dm_o}, 0);
        if (!v[31]) exp_addr = v[18:12];
        chk(dev_addr_o == exp_addr, v[31] ? "R10 hs" : "R10 data", "dev_addr",
            dev_addr_o, exp_addr);
        if (poke) begin
            bad_busy = 0;
            repeat (20) begin
                @(negedge clk);
                if (busy_o || oe_o) bad_busy++;
            end
            chk(bad_busy == 0, "R11", "start while busy started a packet", bad_busy, 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!busy_o && !oe_o && !dp_o && !dm_o, "R1", "reset pins",
            {busy_o, oe_o, dp_o, dm_o}, 0);
        chk(dev_addr_o == 7'h0, "R1", "reset addr", dev_addr_o, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int t = 0; t < 7; t++) run_pkt(VEC[t], 1'b0);

        // R11: a strobe mid-packet changes nothing
        run_pkt({1'b0, 8'h00, 4'd5, 7'h44, 2'd2, 2'b0, 8'h17}, 1'b1);

        // R1: reset in the middle of a packet
        @(negedge clk);
        new_addr_i = 7'h66;
        hs_sel_i   = 1'b0;
        len_i      = 4'd6;
        start_i    = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (40) @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(!busy_o && !oe_o && !dp_o && !dm_o, "R1", "mid-packet reset pins",
            {busy_o, oe_o, dp_o, dm_o}, 0);
        chk(dev_addr_o == 7'h0, "R1", "mid-packet reset addr", dev_addr_o, 0);
        exp_addr = '0;
        rst_n = 1'b1;
        @(negedge clk);
        run_pkt({1'b1, 8'hD2, 4'd7, 7'h22, 2'd0, 2'b0, 8'h00}, 1'b0);
        run_pkt({1'b0, 8'h00, 4'd2, 7'h0C, 2'd1, 2'b0, 8'h00}, 1'b0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule